// File: doc/BRIEF.md
# DMA Sector Progress Tracker

This block follows the progress of a descriptor-driven DMA transfer for two kinds of storage target. The first is a hard-disk style device that counts 512-byte sectors. The second is an optical packet device that counts 2048-byte logical blocks and carries a byte offset within the current block. The block does not move data and does not parse descriptors. It keeps the position bookkeeping that sits between them.

A command is loaded with a `start` pulse. The pulse carries the device kind, the starting sector or block, the sector count or packet byte count, and the length of the first descriptor. The load also performs a zero-size progress step. After that, each `chunk_done` pulse reports the byte size of the chunk that has just finished. The block then updates the position, the remaining amount and the in-block offset. Next it either launches the following chunk, whose length is the current `next_len`, or ends the DMA if that length is zero. For each launch the block presents the media address in 512-byte units.

Command completion is signalled in two ways. The first is a ready/seek-complete status byte and a done level. The second is an interrupt level, which stays set until `irq_ack` clears it. A chunk that reports an error stops the transfer at once and leaves every counter where it was.

Top module: `dma_progress_tracker`

## Requirements
- R1: In disk mode, a finished chunk of S bytes (S nonzero) adds ceil(S/512) to the sector number and subtracts the same amount from the remaining sector count.
- R2: In disk mode, when the remaining count reaches zero, `cmd_done` goes to 1, `status` becomes 8'h50 (ready plus seek-complete) and `irq` is raised.
- R3: In packet mode, the chunk size is added to an 11-bit byte offset. The block number grows by sum/2048, and the offset keeps sum mod 2048.
- R4: In packet mode, the signed packet byte count falls by the chunk size. The command is complete (`cmd_done`=1, `status`=8'h50, `irq` raised) as soon as the count is zero or negative.
- R5: In packet mode, `media_addr` equals block*4 plus offset/512. In disk mode, `media_addr` equals the sector number.
- R6: After each progress step, a `next_len` of zero gives a one-cycle `dma_end` pulse and stops the transfer. A nonzero `next_len` gives a one-cycle `launch` pulse with `launch_len` equal to `next_len`. The two pulses never occur together.
- R7: A `chunk_done` with `chunk_err`=1 during a transfer gives a `dma_end` pulse and sets `status` to 8'h41. It raises `irq` and leaves `media_addr` and all counters unchanged.
- R8: `irq` is a level. It holds until `irq_ack` is pulsed. A new set in the same cycle as an acknowledge wins.
- R9: A `chunk_done` while no transfer is active has no effect: no pulse, and `media_addr` is unchanged.
- R10: `start` applies a zero-size step. `media_addr` takes the start position (packet: position*4). A disk command with count zero completes at once.
- R11: The completion interrupt is raised only when completion is first reached. Later steps of an already complete command do not raise it again.
- R12: After reset, `irq`, `launch`, `dma_end` and `cmd_done` are 0, and `status` and `media_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load a command and apply the zero-size first step |
| start_kind | input | 1 | 0 = disk (sectors), 1 = packet (blocks) |
| start_pos | input | 48 | Starting sector or logical block |
| start_count | input | 16 | Disk sector count |
| start_bytes | input | 32 | Packet byte count (signed) |
| chunk_done | input | 1 | A launched chunk has finished |
| chunk_bytes | input | 24 | Size in bytes of the finished chunk |
| chunk_err | input | 1 | The finished chunk failed |
| next_len | input | 24 | Length of the next descriptor, 0 when none |
| irq_ack | input | 1 | Clears the interrupt level |
| launch | output | 1 | One-cycle request to start the next chunk |
| launch_len | output | 24 | Byte length of the launched chunk |
| media_addr | output | 48 | Media address in 512-byte units for the next chunk |
| dma_end | output | 1 | One-cycle end-of-DMA pulse |
| cmd_done | output | 1 | Command completion level |
| status | output | 8 | Device status byte |
| irq | output | 1 | Interrupt level |

## Verification
The assertions assume that a disk chunk never covers more sectors than remain. They also assume that `chunk_done` arrives only for a chunk that was launched, and that `start` is not sent while an earlier command's chunk is finishing. The stimulus keeps within these limits. Every disk chunk in the vector table and in the directed tests is sized at or below the remaining count. Each `chunk_done` follows a `launch` or is sent only after `dma_end`, as the deliberate idle-ignore case. The packet cases choose sizes that carry across one or more 2048-byte boundaries and drive the signed byte count below zero.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
   typedef enum logic {
      DEV_DISK   = 1'b0,
      DEV_PACKET = 1'b1
   } dev_kind_e;

   localparam logic [7:0] ST_IDLE       = 8'h00;
   localparam logic [7:0] ST_BUSY       = 8'h80;
   localparam logic [7:0] ST_READY_SEEK = 8'h50;
   localparam logic [7:0] ST_FAULT      = 8'h41;
endpackage

// File: rtl/dpt_disk_step.sv
module dpt_disk_step #(
   parameter int ADDR_W     = 48,
   parameter int CNT_W      = 16,
   parameter int LEN_W      = 24,
   parameter int SECT_SHIFT = 9
) (
   input  logic [ADDR_W-1:0] pos_i,
   input  logic [CNT_W-1:0]  rem_i,
   input  logic [LEN_W-1:0]  size_i,
   output logic [ADDR_W-1:0] pos_o,
   output logic [CNT_W-1:0]  rem_o,
   output logic              fin_o,
   output logic              under_o
);
   localparam int          SUM_W = LEN_W + 1;
   localparam logic [SUM_W-1:0] ROUND = SUM_W'((1 << SECT_SHIFT) - 1);

   logic [SUM_W-1:0] rounded;
   logic [SUM_W-1:0] nsec;

   always_comb begin
      rounded = {1'b0, size_i} + ROUND;
      nsec    = rounded >> SECT_SHIFT;
      pos_o   = pos_i + ADDR_W'(nsec);
      rem_o   = rem_i - CNT_W'(nsec);
      fin_o   = (rem_o == '0);
      under_o = (nsec > SUM_W'(rem_i));
   end
endmodule

// File: rtl/dpt_pkt_step.sv
module dpt_pkt_step #(
   parameter int ADDR_W     = 48,
   parameter int BYTES_W    = 32,
   parameter int LEN_W      = 24,
   parameter int SECT_SHIFT = 9,
   parameter int BLK_SHIFT  = 11
) (
   input  logic [ADDR_W-1:0]         blk_i,
   input  logic [BLK_SHIFT-1:0]      off_i,
   input  logic signed [BYTES_W-1:0] bytes_i,
   input  logic [LEN_W-1:0]          size_i,
   output logic [ADDR_W-1:0]         blk_o,
   output logic [BLK_SHIFT-1:0]      off_o,
   output logic signed [BYTES_W-1:0] bytes_o,
   output logic [ADDR_W-1:0]         media_o,
   output logic                      fin_o
);
   localparam int SUM_W    = LEN_W + 1;
   localparam int SUB_BITS = BLK_SHIFT - SECT_SHIFT;

   logic [SUM_W-1:0]          sum;
   logic signed [BYTES_W-1:0] size_s;

   always_comb begin
      sum     = {1'b0, size_i} + SUM_W'(off_i);
      blk_o   = blk_i + ADDR_W'(sum >> BLK_SHIFT);
      off_o   = sum[BLK_SHIFT-1:0];
      size_s  = BYTES_W'(size_i);
      bytes_o = bytes_i - size_s;
      media_o = (blk_o << SUB_BITS) + ADDR_W'(off_o >> SECT_SHIFT);
      fin_o   = bytes_o[BYTES_W-1] || (bytes_o == '0);
   end
endmodule

// File: rtl/dpt_irq_ctl.sv
module dpt_irq_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic ack_i,
   output logic irq_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      irq_o <= 1'b0;
      else if (set_i)  irq_o <= 1'b1;
      else if (ack_i)  irq_o <= 1'b0;
   end

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ack_i) |=> irq_o); // R8
   AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> irq_o); // R8
endmodule

// File: rtl/dma_progress_tracker.sv
module dma_progress_tracker
   import dpt_pkg::*;
#(
   parameter int ADDR_W     = 48,
   parameter int CNT_W      = 16,
   parameter int BYTES_W    = 32,
   parameter int LEN_W      = 24,
   parameter int SECT_SHIFT = 9,
   parameter int BLK_SHIFT  = 11,
   parameter bit HAS_PACKET = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic                      start_kind,
   input  logic [ADDR_W-1:0]         start_pos,
   input  logic [CNT_W-1:0]          start_count,
   input  logic signed [BYTES_W-1:0] start_bytes,
   input  logic                      chunk_done,
   input  logic [LEN_W-1:0]          chunk_bytes,
   input  logic                      chunk_err,
   input  logic [LEN_W-1:0]          next_len,
   input  logic                      irq_ack,
   output logic                      launch,
   output logic [LEN_W-1:0]          launch_len,
   output logic [ADDR_W-1:0]         media_addr,
   output logic                      dma_end,
   output logic                      cmd_done,
   output logic [7:0]                status,
   output logic                      irq
);
   if (BLK_SHIFT <= SECT_SHIFT) begin : g_bad_shift
      $error("BLK_SHIFT must exceed SECT_SHIFT");
   end
   if (LEN_W < BLK_SHIFT) begin : g_bad_len
      $error("LEN_W must cover one block offset");
   end
   if (BYTES_W <= LEN_W) begin : g_bad_bytes
      $error("BYTES_W must exceed LEN_W");
   end
   if (ADDR_W <= LEN_W) begin : g_bad_addr
      $error("ADDR_W must exceed LEN_W");
   end

   // architectural state
   logic                      busy_q;
   dev_kind_e                 kind_q;
   logic [ADDR_W-1:0]         pos_q;
   logic [CNT_W-1:0]          rem_q;
   logic [BLK_SHIFT-1:0]      off_q;
   logic signed [BYTES_W-1:0] bytes_q;

   // step selection
   dev_kind_e                 kind_in;
   dev_kind_e                 step_kind;
   logic                      step_go;
   logic                      err_hit;
   logic [LEN_W-1:0]          step_size;
   logic [ADDR_W-1:0]         base_pos;
   logic [CNT_W-1:0]          base_rem;
   logic [BLK_SHIFT-1:0]      base_off;
   logic signed [BYTES_W-1:0] base_bytes;
   logic                      done_before;

   // step results
   logic [ADDR_W-1:0]         dk_pos;
   logic [CNT_W-1:0]          dk_rem;
   logic                      dk_fin;
   logic                      dk_under;
   logic [ADDR_W-1:0]         pk_blk;
   logic [BLK_SHIFT-1:0]      pk_off;
   logic signed [BYTES_W-1:0] pk_bytes;
   logic [ADDR_W-1:0]         pk_media;
   logic                      pk_fin;
   logic                      step_fin;
   logic                      irq_set;

   assign kind_in = (HAS_PACKET && start_kind) ? DEV_PACKET : DEV_DISK;

   always_comb begin
      step_go     = start || (busy_q && chunk_done && !chunk_err);
      err_hit     = !start && busy_q && chunk_done && chunk_err;
      step_kind   = start ? kind_in : kind_q;
      step_size   = start ? '0 : chunk_bytes;
      base_pos    = start ? start_pos : pos_q;
      base_rem    = start ? start_count : rem_q;
      base_off    = start ? '0 : off_q;
      base_bytes  = start ? start_bytes : bytes_q;
      done_before = start ? 1'b0 : cmd_done;
      step_fin    = (step_kind == DEV_PACKET) ? pk_fin : dk_fin;
      irq_set     = (step_go && step_fin && !done_before) || err_hit;
   end

   dpt_disk_step #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .SECT_SHIFT(SECT_SHIFT)
   ) u_disk (
      .pos_i(base_pos), .rem_i(base_rem), .size_i(step_size),
      .pos_o(dk_pos), .rem_o(dk_rem), .fin_o(dk_fin), .under_o(dk_under)
   );

   if (HAS_PACKET) begin : g_pkt
      dpt_pkt_step #(
         .ADDR_W(ADDR_W), .BYTES_W(BYTES_W), .LEN_W(LEN_W),
         .SECT_SHIFT(SECT_SHIFT), .BLK_SHIFT(BLK_SHIFT)
      ) u_pkt (
         .blk_i(base_pos), .off_i(base_off), .bytes_i(base_bytes),
         .size_i(step_size), .blk_o(pk_blk), .off_o(pk_off),
         .bytes_o(pk_bytes), .media_o(pk_media), .fin_o(pk_fin)
      );
   end else begin : g_no_pkt
      assign pk_blk   = '0;
      assign pk_off   = '0;
      assign pk_bytes = '0;
      assign pk_media = '0;
      assign pk_fin   = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         kind_q     <= DEV_DISK;
         pos_q      <= '0;
         rem_q      <= '0;
         off_q      <= '0;
         bytes_q    <= '0;
         launch     <= 1'b0;
         launch_len <= '0;
         media_addr <= '0;
         dma_end    <= 1'b0;
         cmd_done   <= 1'b0;
         status     <= ST_IDLE;
      end else begin
         launch  <= 1'b0;
         dma_end <= 1'b0;
         if (step_go) begin
            kind_q <= step_kind;
            rem_q  <= dk_rem;
            off_q  <= pk_off;
            bytes_q <= pk_bytes;
            if (step_kind == DEV_PACKET) begin
               pos_q      <= pk_blk;
               media_addr <= pk_media;
            end else begin
               pos_q      <= dk_pos;
               media_addr <= dk_pos;
            end
            if (step_fin) begin
               cmd_done <= 1'b1;
               status   <= ST_READY_SEEK;
            end else if (start) begin
               cmd_done <= 1'b0;
               status   <= ST_BUSY;
            end
            if (next_len == '0) begin
               dma_end <= 1'b1;
               busy_q  <= 1'b0;
            end else begin
               launch     <= 1'b1;
               launch_len <= next_len;
               busy_q     <= 1'b1;
            end
         end else if (err_hit) begin
            dma_end <= 1'b1;
            busy_q  <= 1'b0;
            status  <= ST_FAULT;
         end
      end
   end

   dpt_irq_ctl u_irq (
      .clk(clk), .rst_n(rst_n), .set_i(irq_set), .ack_i(irq_ack), .irq_o(irq)
   );

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && chunk_done && !chunk_err && !start && kind_q == DEV_DISK)
      |-> !dk_under); // R1
   AST_DONE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_done) |-> (status == ST_READY_SEEK)); // R2
   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(launch && dma_end)); // R6
   AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && chunk_done && chunk_err && !start)
      |=> ($stable(media_addr) && dma_end && status == ST_FAULT)); // R7
   AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && chunk_done && !start)
      |=> ($stable(media_addr) && !launch && !dma_end)); // R9
endmodule

// File: tb/sim_dma_progress_tracker.sv
module sim_dma_progress_tracker;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;

   typedef struct packed {
      logic        kind;
      logic [47:0] pos;
      logic [15:0] cnt;
      logic [31:0] bytes;
      logic [23:0] len;
      logic [47:0] start_media;
      logic [47:0] exp_media;
      logic        exp_done;
   } vec_t;

   // disk: media = pos + ceil(len/512); packet: block*4 + offset/512
   localparam vec_t VECS [NVEC] = '{
      '{1'b0, 48'd100, 16'd4, 32'd0, 24'd2048, 48'd100, 48'd104, 1'b1},
      '{1'b0, 48'd0, 16'd8, 32'd0, 24'd1000, 48'd0, 48'd2, 1'b0},
      '{1'b0, 48'h0000_FFFF_FFFF, 16'd1, 32'd0, 24'd1, 48'h0000_FFFF_FFFF,
        48'h0001_0000_0000, 1'b1},
      '{1'b0, 48'd7, 16'd3, 32'd0, 24'd512, 48'd7, 48'd8, 1'b0},
      '{1'b1, 48'd10, 16'd0, 32'd2048, 24'd2048, 48'd40, 48'd44, 1'b1},
      '{1'b1, 48'd0, 16'd0, 32'd4096, 24'd1024, 48'd0, 48'd2, 1'b0},
      '{1'b1, 48'd5, 16'd0, 32'd100, 24'd600, 48'd20, 48'd21, 1'b1},
      '{1'b1, 48'd1, 16'd0, 32'd5000, 24'd5000, 48'd4, 48'd13, 1'b1}
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic               start_kind = 1'b0;
   logic [47:0]        start_pos = '0;
   logic [15:0]        start_count = '0;
   logic signed [31:0] start_bytes = '0;
   logic               chunk_done = 1'b0;
   logic [23:0]        chunk_bytes = '0;
   logic               chunk_err = 1'b0;
   logic [23:0]        next_len = '0;
   logic               irq_ack = 1'b0;
   logic               launch;
   logic [23:0]        launch_len;
   logic [47:0]        media_addr;
   logic               dma_end;
   logic               cmd_done;
   logic [7:0]         status;
   logic               irq;

   int nchk = 0;
   int nerr = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dma_progress_tracker u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .start_kind(start_kind),
      .start_pos(start_pos), .start_count(start_count), .start_bytes(start_bytes),
      .chunk_done(chunk_done), .chunk_bytes(chunk_bytes), .chunk_err(chunk_err),
      .next_len(next_len), .irq_ack(irq_ack), .launch(launch),
      .launch_len(launch_len), .media_addr(media_addr), .dma_end(dma_end),
      .cmd_done(cmd_done), .status(status), .irq(irq)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_start(input logic k, input logic [47:0] p, input logic [15:0] c,
                           input logic [31:0] b, input logic [23:0] nl);
      @(negedge clk);
      start = 1'b1; start_kind = k; start_pos = p; start_count = c;
      start_bytes = b; next_len = nl;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic do_chunk(input logic [23:0] sz, input logic e, input logic [23:0] nl);
      @(negedge clk);
      chunk_done = 1'b1; chunk_bytes = sz; chunk_err = e; next_len = nl;
      @(negedge clk);
      chunk_done = 1'b0; chunk_err = 1'b0;
   endtask

   task automatic do_ack();
      @(negedge clk);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 irq", 64'(irq), 64'd0);
      chk("R12 launch", 64'(launch), 64'd0);
      chk("R12 dma_end", 64'(dma_end), 64'd0);
      chk("R12 cmd_done", 64'(cmd_done), 64'd0);
      chk("R12 status", 64'(status), 64'd0);
      chk("R12 media", 64'(media_addr), 64'd0);
      rst_n = 1'b1;

      // vector table: start, one chunk, end (R1 R2 R3 R4 R5 R6 R10)
      for (int i = 0; i < NVEC; i++) begin
         do_ack();
         do_start(VECS[i].kind, VECS[i].pos, VECS[i].cnt, VECS[i].bytes, VECS[i].len);
         chk("R6 launch", 64'(launch), 64'd1);
         chk("R6 launch_len", 64'(launch_len), 64'(VECS[i].len));
         chk("R10 start media", 64'(media_addr), 64'(VECS[i].start_media));
         chk("R10 start status", 64'(status), 64'h80);
         do_chunk(VECS[i].len, 1'b0, 24'd0);
         chk("R6 dma_end", 64'(dma_end), 64'd1);
         chk("R6 no launch", 64'(launch), 64'd0);
         chk(VECS[i].kind ? "R5 R3 packet media" : "R1 disk media",
             64'(media_addr), 64'(VECS[i].exp_media));
         chk(VECS[i].kind ? "R4 done" : "R2 done", 64'(cmd_done), 64'(VECS[i].exp_done));
         chk(VECS[i].kind ? "R4 irq" : "R2 irq", 64'(irq), 64'(VECS[i].exp_done));
         chk("R2 status", 64'(status), VECS[i].exp_done ? 64'h50 : 64'h80);
      end

      // R3 multi-chunk carry across block boundary
      do_ack();
      do_start(1'b1, 48'd0, 16'd0, 32'd3000, 24'd1500);
      do_chunk(24'd1500, 1'b0, 24'd1500);
      chk("R3 mid media", 64'(media_addr), 64'd2);
      chk("R6 mid launch", 64'(launch), 64'd1);
      chk("R4 mid not done", 64'(cmd_done), 64'd0);
      do_chunk(24'd1500, 1'b0, 24'd0);
      chk("R3 carry media", 64'(media_addr), 64'd5);
      chk("R4 zero done", 64'(cmd_done), 64'd1);

      // R11 completion interrupt only on first arrival
      do_ack();
      do_start(1'b1, 48'd0, 16'd0, 32'd100, 24'd600);
      do_chunk(24'd600, 1'b0, 24'd600);
      chk("R11 first irq", 64'(irq), 64'd1);
      chk("R5 media", 64'(media_addr), 64'd1);
      do_ack();
      chk("R8 ack clears", 64'(irq), 64'd0);
      do_chunk(24'd600, 1'b0, 24'd0);
      chk("R11 no re-raise", 64'(irq), 64'd0);
      chk("R11 media", 64'(media_addr), 64'd2);
      chk("R11 dma_end", 64'(dma_end), 64'd1);

      // R7 error on chunk
      do_ack();
      do_start(1'b0, 48'd50, 16'd4, 32'd0, 24'd512);
      do_chunk(24'd512, 1'b1, 24'd512);
      chk("R7 dma_end", 64'(dma_end), 64'd1);
      chk("R7 no launch", 64'(launch), 64'd0);
      chk("R7 media frozen", 64'(media_addr), 64'd50);
      chk("R7 status", 64'(status), 64'h41);
      chk("R7 irq", 64'(irq), 64'd1);
      chk("R7 not done", 64'(cmd_done), 64'd0);

      // R10 zero count completes at once
      do_ack();
      do_start(1'b0, 48'd9, 16'd0, 32'd0, 24'd0);
      chk("R10 done", 64'(cmd_done), 64'd1);
      chk("R10 irq", 64'(irq), 64'd1);
      chk("R10 dma_end", 64'(dma_end), 64'd1);
      chk("R10 media", 64'(media_addr), 64'd9);

      // R9 chunk while idle ignored
      do_chunk(24'd512, 1'b0, 24'd512);
      chk("R9 media", 64'(media_addr), 64'd9);
      chk("R9 launch", 64'(launch), 64'd0);
      chk("R9 dma_end", 64'(dma_end), 64'd0);

      // R8 level holds until ack
      repeat (3) @(negedge clk);
      chk("R8 hold", 64'(irq), 64'd1);
      do_ack();
      chk("R8 cleared", 64'(irq), 64'd0);

      summary();
      $finish;
   end
endmodule